// File: doc/BRIEF.md
# One-Bit Stream Decimating Low-Pass Filter

This block turns the single-bit output of a delta-sigma modulator into a stream of multi-bit PCM samples. Every accepted bit enters a tap delay line. The bit is treated as a bipolar unit: a 0 stands for +1 and a 1 stands for -1. Because of that, each tap adds or subtracts a fixed-point coefficient, and no multiplier is needed. The filter keeps only every DECIM-th filtered value. The adder tree is evaluated only in the input period that closes a decimation group, and that result is registered.

The coefficients are fixed at elaboration by a closed formula. No outputs are issued while the delay line still holds reset fill, so every sample that leaves the block is bit-exact against a plain arithmetic model of the same filter.

Top module: `bsdec_fir`

## Requirements
- R1: An accepted input bit of 0 has the value +1 and an accepted bit of 1 has the value -1; neither reading 0/1 nor 0/-1 is used.
- R2: Each emitted sample equals the sum over k = 0..NTAPS-1 of c[k]·v[n-k], where v[n] is the value of the newest accepted bit (the one that completes the group) and c[k] = 256·min(k+1, NTAPS-k) − 600, a CW-bit signed value.
- R3: The output is CW+clog2(NTAPS)+1 bits signed, wide enough that no combination of inputs can wrap; its magnitude never exceeds the sum of |c[k]|.
- R4: One sample is emitted after every DECIM accepted bits. out_valid is high for exactly one cycle, in the cycle after the clock edge that accepts the bit completing the group.
- R5: No sample is emitted until at least NTAPS bits have been accepted since reset. Groups that complete earlier produce no out_valid pulse.
- R6: A cycle with in_valid low is ignored. in_bit has no effect, and neither the delay line nor the group position advances.
- R7: A synchronous reset clears the delay line to all 0 bits (+1 values) and sets the group position and the fill count to zero. It also drives out_valid and out_data to 0.
- R8: out_data changes only in a cycle where out_valid is high, and holds its value between samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | in_bit carries a new modulator bit this cycle |
| in_bit | input | 1 | Modulator bit (0 = +1, 1 = -1) |
| out_valid | output | 1 | One-cycle strobe marking a new PCM sample |
| out_data | output | CW+clog2(NTAPS)+1 | Signed PCM sample |

## Verification
On every cycle, the embedded properties check the following: a strobe only follows an accepted bit and lands at the start of a new group; no strobe comes before the delay line is full; the result stays inside the coefficient magnitude bound; idle cycles leave the stored state untouched; and out_data holds between strobes. The actual arithmetic can only be shown by the bench's scenarios. These cover the sign mapping, the tap ordering and the coefficient formula, and the scenarios are constant ones, constant zeros, alternating bits, a pseudo-random stream, idle gaps carrying garbage on in_bit, and a reset in mid-stream. In each scenario, every sample is compared against an independent arithmetic model.

// File: rtl/bsdec_fir.sv
module bsdec_fir #(
  parameter int NTAPS = 32,
  parameter int CW    = 16,
  parameter int DECIM = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic                          in_bit,
  output logic                          out_valid,
  output logic signed [CW+$clog2(NTAPS):0] out_data
);

  localparam int AW = CW + $clog2(NTAPS) + 1;
  localparam int PW = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam int FW = $clog2(NTAPS + 1);

  function automatic logic signed [CW-1:0] coef(input int k);
    int t;
    t = (k + 1 < NTAPS - k) ? k + 1 : NTAPS - k;
    return CW'(256 * t - 600);
  endfunction

  function automatic logic signed [AW-1:0] abs_total();
    logic signed [AW-1:0] s;
    logic signed [AW-1:0] c;
    s = '0;
    for (int k = 0; k < NTAPS; k++) begin
      c = AW'(coef(k));
      s = s + ((c < 0) ? -c : c);
    end
    return s;
  endfunction

  localparam logic signed [AW-1:0] BOUND = abs_total();

  logic [NTAPS-1:0] dline_q;
  logic [PW-1:0]    phase_q;
  logic [FW-1:0]    fill_q;

  // newest bit sits at index 0
  logic [NTAPS-1:0] nxt;
  assign nxt = {dline_q[NTAPS-2:0], in_bit};

  logic signed [AW-1:0] term [NTAPS];
  logic signed [AW-1:0] acc;

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    localparam logic signed [AW-1:0] CK = AW'(coef(k));
    assign term[k] = nxt[k] ? -CK : CK;
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NTAPS; k++) acc = acc + term[k];
  end

  logic last, full, emit;
  assign last = (phase_q == PW'(DECIM - 1));
  assign full = (fill_q == FW'(NTAPS));
  assign emit = in_valid && last && (full || fill_q == FW'(NTAPS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      dline_q   <= '0;
      phase_q   <= '0;
      fill_q    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= emit;
      if (in_valid) begin
        dline_q <= nxt;
        phase_q <= last ? '0 : phase_q + 1'b1;
        if (!full) fill_q <= fill_q + 1'b1;
      end
      if (emit) out_data <= acc;
    end
  end

  AST_FROM_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid)); // R4
  AST_GROUP_START: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> phase_q == '0); // R4
  AST_NO_EARLY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> fill_q == FW'(NTAPS)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data <= BOUND && out_data >= -BOUND)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(dline_q) && $stable(phase_q) && !out_valid)); // R6
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data)); // R8

endmodule

// File: tb/bsdec_fir_tb.sv
module bsdec_fir_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NTAPS = 32;
  localparam int CW    = 16;
  localparam int DECIM = 8;
  localparam int AW    = CW + $clog2(NTAPS) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic out_valid;
  logic signed [AW-1:0] out_data;

  int total = 0;
  int bad = 0;
  logic hist [NTAPS];
  int count = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bsdec_fir #(.NTAPS(NTAPS), .CW(CW), .DECIM(DECIM)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic longint cval(input int k);
    int t;
    t = (k + 1 < NTAPS - k) ? k + 1 : NTAPS - k;
    return longint'(256 * t - 600);
  endfunction

  function automatic longint model();
    longint s;
    s = 0;
    for (int k = 0; k < NTAPS; k++) s += hist[k] ? -cval(k) : cval(k);
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    for (int k = 0; k < NTAPS; k++) hist[k] = 1'b0;
    count = 0;
  endtask

  task automatic push(input logic b);
    bit want;
    in_valid = 1'b1;
    in_bit = b;
    @(posedge clk);
    #1;
    for (int k = NTAPS - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = b;
    count++;
    want = (count % DECIM == 0) && (count >= NTAPS);
    if (count % DECIM == 0 && count < NTAPS)
      chk(out_valid == 1'b0, "R5 early group suppressed", out_valid, 0);
    else
      chk(out_valid == want, "R4 strobe timing", out_valid, want);
    if (want) chk(out_data == model(), "R2 sample value", out_data, model());
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      in_bit = i[0];
      @(posedge clk);
      #1;
      chk(out_valid == 1'b0, "R6 idle cycle strobe", out_valid, 0);
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(out_valid == 1'b0, "R7 reset out_valid", out_valid, 0);
    chk(out_data == 0, "R7 reset out_data", out_data, 0);
  endtask

  task automatic t_ones();
    longint s;
    do_reset();
    s = 0;
    for (int k = 0; k < NTAPS; k++) s += cval(k);
    for (int i = 0; i < 4 * NTAPS; i++) begin
      push(1'b1);
      if (count >= NTAPS && count % DECIM == 0)
        chk(out_data == -s, "R1 ones read as -1", out_data, -s);
    end
  endtask

  task automatic t_zeros();
    longint s;
    do_reset();
    s = 0;
    for (int k = 0; k < NTAPS; k++) s += cval(k);
    for (int i = 0; i < 3 * NTAPS; i++) begin
      push(1'b0);
      if (count >= NTAPS && count % DECIM == 0)
        chk(out_data == s, "R1 zeros read as +1", out_data, s);
    end
  endtask

  task automatic t_alternate();
    do_reset();
    for (int i = 0; i < 3 * NTAPS + 3; i++) push(i[0]);
  endtask

  task automatic t_prbs();
    logic [15:0] lfsr;
    do_reset();
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      push(lfsr[0]);
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    end
  endtask

  task automatic t_gaps();
    logic [15:0] lfsr;
    do_reset();
    lfsr = 16'h1D2B;
    for (int i = 0; i < 200; i++) begin
      push(lfsr[1]);
      if (lfsr[3:2] == 2'b00) idle(1 + int'(lfsr[5:4]));
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    end
    // held state must survive a long idle run
    idle(20);
    chk(out_data == model() || count % DECIM != 0, "R8 output held", out_data, model());
  endtask

  task automatic t_mid_reset();
    do_reset();
    for (int i = 0; i < NTAPS + 12; i++) push(1'b1);
    do_reset();
    chk(out_valid == 1'b0, "R7 mid reset strobe", out_valid, 0);
    chk(out_data == 0, "R7 mid reset data", out_data, 0);
    for (int i = 0; i < NTAPS + DECIM; i++) push(i < 3 ? 1'b1 : 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_ones();
    t_zeros();
    t_alternate();
    t_prbs();
    t_gaps();
    t_mid_reset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule